// File: doc/BRIEF.md
# Flash Program and Erase Strobe Sequencer

This block drives the control strobes of an embedded non-volatile memory array through word program, page erase and mass erase operations. A host presents an operation code, a word address and write data together with a one-cycle start pulse. The block then runs a fixed strobe sequence:

1. It drives the address and data.
2. It raises the program or erase enable.
3. It raises the store strobe.
4. It fires the high-voltage pulse.
5. It releases the strobes in reverse order, holding each setup, pulse, hold and recovery interval.

A prescaler turns the system clock into microsecond steps. The number of clocks per microsecond is taken from the `tick_div` input. Every interval length is a parameter given in microseconds.

The block guards the array against overstress. It remembers which words have been written since their row was last erased. It also keeps a running total of high-voltage time per row. A request is refused with a one-cycle `done` and `err` pulse, and no strobe moves, in three cases:
- a word program to a word that was already written;
- a word program that would push its row past the high-voltage budget;
- an undefined operation code.

A page erase resets the bookkeeping of its row. A mass erase resets the bookkeeping of every row.

The controller has eight states:

| State | What happens |
|---|---|
| IDLE | Waits for a command. |
| SETUP | One cycle of address and data before any strobe. |
| ARM | The enable is high and the store strobe is still low. |
| STORE | Program only: the store strobe is high and the pulse has not started. |
| PULSE | The high-voltage pulse. |
| PGH | One cycle in which the enable outlives the pulse. |
| HOLD | The enable is low and the store strobe is still high. |
| RECOVER | All strobes are low. |

It has these transitions:

| From | To | Condition |
|---|---|---|
| IDLE | SETUP | A start is accepted. |
| IDLE | IDLE | A start is refused. |
| SETUP | ARM | Always. |
| ARM | STORE | Program, when its timer expires. |
| ARM | PULSE | Erase, when its timer expires. |
| STORE | PULSE | On timer expiry. |
| PULSE | PGH | On timer expiry. |
| PGH | HOLD | Always. |
| HOLD | RECOVER | On timer expiry. |
| RECOVER | IDLE | On timer expiry, with `done` in the following cycle. |

Top module: `flash_pe_sequencer`

## Requirements
- R1: After reset and whenever no command is running, `busy`, `done`, `err`, `prog_en`, `erase_en`, `mass_sel`, `nvstr` and `hv_pulse` are all 0.
- R2: A start that is accepted in IDLE makes `busy` high from the next cycle on. The first busy cycle shows the latched address and data with every strobe still low.
- R3: The enable (`prog_en` for op 0, `erase_en` for ops 1 and 2) is high for TNVS_US×D clock cycles before `nvstr` rises. D is `tick_div`, and a value of 0 counts as 1.
- R4: In a word program, `hv_pulse` rises TPGS_US×D cycles after `nvstr` and stays high for TPROG_US×D cycles.
- R5: A page erase (op 1) pulses for TERASE_US×D cycles and a mass erase (op 2) for TME_US×D cycles. In an erase, `nvstr` and `hv_pulse` rise together. `mass_sel` is high for the whole of a mass erase, and `prog_en` and `erase_en` are never high together.
- R6: After the pulse the enable stays high for one more cycle. `nvstr` then stays high for TNVH_US×D cycles, or TNVH1_US×D cycles for a mass erase.
- R7: After `nvstr` falls, `busy` stays high with all strobes low for TRCV_US×D cycles. Then `done` is high for one cycle with `busy` low.
- R8: A start that arrives while `busy` is high is ignored, and its operation is never carried out.
- R9: A word program to an address already programmed since its row's last erase is refused. `done` and `err` are high together in the next cycle, and `busy` and the strobes stay low.
- R10: A word program whose row total of programmed microseconds plus TPROG_US would exceed HV_LIMIT_US is refused in the same way as in R9. Rows are groups of WORDS_PER_ROW consecutive addresses.
- R11: A page erase clears the programmed flags and the high-voltage total of the row holding its address only. A mass erase clears them for all rows.
- R12: Op code 3 is refused in the same way as in R9.
- R13: `fl_addr` and `fl_data` do not change while `busy` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_div | input | DIV_W | Clock cycles per microsecond; 0 counts as 1; must be held stable while busy |
| start | input | 1 | One-cycle command request |
| op | input | 2 | 0 word program, 1 page erase, 2 mass erase, 3 undefined |
| addr | input | ADDR_W | Word address; for a page erase, any word of the row |
| wdata | input | DATA_W | Word to program |
| busy | output | 1 | A command is running |
| done | output | 1 | One-cycle completion or refusal pulse |
| err | output | 1 | High with `done` when the request was refused |
| fl_addr | output | ADDR_W | Address driven to the array |
| fl_data | output | DATA_W | Data driven to the array |
| prog_en | output | 1 | Program enable strobe |
| erase_en | output | 1 | Erase enable strobe |
| mass_sel | output | 1 | Selects the whole array for an erase |
| nvstr | output | 1 | Store strobe |
| hv_pulse | output | 1 | High-voltage pulse |

## Verification
Every result is due a fixed number of cycles after the start edge. The busy window opens one cycle later. A refusal's `done`/`err` pulse also appears one cycle later. Each timed phase then lasts its microsecond count times `tick_div` cycles, and `done` follows the last recovery cycle by one cycle. The bench turns each accepted or refused command into a queue of expected strobe vectors, one vector per cycle, and compares a vector at every falling edge. A strobe that comes early or late therefore mismatches in the cycle where it should have moved. Refusals, ignored starts and erase clearing are told apart by what later commands do, as predicted by the bench's own per-address and per-row bookkeeping.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

    typedef enum logic [1:0] {
        OP_PROG = 2'd0,
        OP_PAGE = 2'd1,
        OP_MASS = 2'd2,
        OP_BAD  = 2'd3
    } fl_op_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_SETUP,
        S_ARM,
        S_STORE,
        S_PULSE,
        S_PGH,
        S_HOLD,
        S_RECOVER
    } fl_state_e;

endpackage

// File: rtl/fseq_us_prescaler.sv
// Divides the clock into microsecond steps; restart realigns the step grid
// to the first cycle of a new phase.
module fseq_us_prescaler #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [DIV_W-1:0] div,
    output logic             stb
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] lim;

    assign lim = (div == '0) ? '0 : div - 1'b1;
    assign stb = (cnt == lim);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cnt <= '0;
        else if (restart || stb) cnt <= '0;
        else                     cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/fseq_phase_timer.sv
// Counts microsecond steps of the current phase; expire marks its last cycle.
module fseq_phase_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             stb,
    output logic             expire
);
    logic [CNT_W-1:0] remaining;

    assign expire = stb && (remaining <= CNT_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                       remaining <= '0;
        else if (load)                    remaining <= load_val;
        else if (stb && remaining != '0)  remaining <= remaining - 1'b1;
    end
endmodule

// File: rtl/fseq_row_tracker.sv
// Per-word written flags and per-row high-voltage totals (in microseconds).
module fseq_row_tracker #(
    parameter int ROWS          = 4,
    parameter int WORDS_PER_ROW = 8,
    parameter int TPROG_US      = 20,
    parameter int HV_LIMIT_US   = 3000,
    localparam int WORDS  = ROWS * WORDS_PER_ROW,
    localparam int ADDR_W = $clog2(WORDS),
    localparam int WORD_W = $clog2(WORDS_PER_ROW),
    localparam int ROW_W  = ADDR_W - WORD_W,
    localparam int HV_W   = $clog2(HV_LIMIT_US + TPROG_US + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              commit_prog,
    input  logic              clear_row,
    input  logic              clear_all,
    output logic              already_prog,
    output logic              over_budget
);
    logic             written [WORDS];
    logic [HV_W-1:0]  hv_used [ROWS];
    logic [ROW_W-1:0] row_idx;

    assign row_idx      = addr[ADDR_W-1:WORD_W];
    assign already_prog = written[addr];
    assign over_budget  = (32'(hv_used[row_idx]) + TPROG_US) > HV_LIMIT_US;

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                hv_used[r] <= '0;
            else if (clear_all || (clear_row && row_idx == ROW_W'(r)))
                hv_used[r] <= '0;
            else if (commit_prog && row_idx == ROW_W'(r))
                hv_used[r] <= hv_used[r] + HV_W'(TPROG_US);
        end
    end

    for (genvar w = 0; w < WORDS; w++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                written[w] <= 1'b0;
            else if (clear_all || (clear_row && row_idx == ROW_W'(w / WORDS_PER_ROW)))
                written[w] <= 1'b0;
            else if (commit_prog && addr == ADDR_W'(w))
                written[w] <= 1'b1;
        end
    end
endmodule

// File: rtl/flash_pe_sequencer.sv
module flash_pe_sequencer
    import flash_seq_pkg::*;
#(
    parameter int ROWS          = 4,
    parameter int WORDS_PER_ROW = 8,
    parameter int DATA_W        = 16,
    parameter int DIV_W         = 8,
    parameter int TNVS_US       = 5,
    parameter int TPGS_US       = 10,
    parameter int TPROG_US      = 20,
    parameter int TERASE_US     = 20000,
    parameter int TME_US        = 100000,
    parameter int TNVH_US       = 5,
    parameter int TNVH1_US      = 100,
    parameter int TRCV_US       = 1,
    parameter int HV_LIMIT_US   = 3000,
    localparam int WORDS  = ROWS * WORDS_PER_ROW,
    localparam int ADDR_W = $clog2(WORDS),
    localparam int CNT_W  = $clog2(TNVS_US + TPGS_US + TPROG_US + TERASE_US + TME_US
                                   + TNVH_US + TNVH1_US + TRCV_US + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  tick_div,
    input  logic              start,
    input  logic [1:0]        op,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [ADDR_W-1:0] fl_addr,
    output logic [DATA_W-1:0] fl_data,
    output logic              prog_en,
    output logic              erase_en,
    output logic              mass_sel,
    output logic              nvstr,
    output logic              hv_pulse
);
    fl_state_e        state_q, state_d;
    fl_op_e           op_q;
    logic             done_q, err_q;
    logic             us_stb, expire, load;
    logic [CNT_W-1:0] load_val;
    logic             already_prog, over_budget;
    logic             legal, take, refuse, en_any;

    // ---------------- request screening ----------------
    always_comb begin
        unique case (fl_op_e'(op))
            OP_PROG: legal = !already_prog && !over_budget;
            OP_PAGE: legal = 1'b1;
            OP_MASS: legal = 1'b1;
            default: legal = 1'b0;
        endcase
    end

    assign take   = start && (state_q == S_IDLE) && legal;
    assign refuse = start && (state_q == S_IDLE) && !legal;

    fseq_row_tracker #(
        .ROWS          (ROWS),
        .WORDS_PER_ROW (WORDS_PER_ROW),
        .TPROG_US      (TPROG_US),
        .HV_LIMIT_US   (HV_LIMIT_US)
    ) u_rows (
        .clk          (clk),
        .rst_n        (rst_n),
        .addr         (addr),
        .commit_prog  (take && fl_op_e'(op) == OP_PROG),
        .clear_row    (take && fl_op_e'(op) == OP_PAGE),
        .clear_all    (take && fl_op_e'(op) == OP_MASS),
        .already_prog (already_prog),
        .over_budget  (over_budget)
    );

    // ---------------- interval timing ----------------
    assign load = (state_d != state_q);

    always_comb begin
        unique case (state_d)
            S_ARM:     load_val = CNT_W'(TNVS_US);
            S_STORE:   load_val = CNT_W'(TPGS_US);
            S_PULSE:   load_val = (op_q == OP_PROG) ? CNT_W'(TPROG_US) :
                                  (op_q == OP_MASS) ? CNT_W'(TME_US) : CNT_W'(TERASE_US);
            S_HOLD:    load_val = (op_q == OP_MASS) ? CNT_W'(TNVH1_US) : CNT_W'(TNVH_US);
            S_RECOVER: load_val = CNT_W'(TRCV_US);
            default:   load_val = CNT_W'(1);
        endcase
    end

    fseq_us_prescaler #(.DIV_W(DIV_W)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (load),
        .div     (tick_div),
        .stb     (us_stb)
    );

    fseq_phase_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (load_val),
        .stb      (us_stb),
        .expire   (expire)
    );

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:    if (take)   state_d = S_SETUP;
            S_SETUP:               state_d = S_ARM;
            S_ARM:     if (expire) state_d = (op_q == OP_PROG) ? S_STORE : S_PULSE;
            S_STORE:   if (expire) state_d = S_PULSE;
            S_PULSE:   if (expire) state_d = S_PGH;
            S_PGH:                 state_d = S_HOLD;
            S_HOLD:    if (expire) state_d = S_RECOVER;
            S_RECOVER: if (expire) state_d = S_IDLE;
            default:               state_d = S_IDLE;
        endcase
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            op_q    <= OP_PROG;
            fl_addr <= '0;
            fl_data <= '0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= refuse || (state_q == S_RECOVER && expire);
            err_q   <= refuse;
            if (take) begin
                op_q    <= fl_op_e'(op);
                fl_addr <= addr;
                fl_data <= wdata;
            end
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        busy     = 1'b1;
        en_any   = 1'b0;
        nvstr    = 1'b0;
        hv_pulse = 1'b0;
        unique case (state_q)
            S_IDLE:    busy = 1'b0;
            S_SETUP:   ;
            S_ARM:     en_any = 1'b1;
            S_STORE:   begin en_any = 1'b1; nvstr = 1'b1; end
            S_PULSE:   begin en_any = 1'b1; nvstr = 1'b1; hv_pulse = 1'b1; end
            S_PGH:     begin en_any = 1'b1; nvstr = 1'b1; end
            S_HOLD:    nvstr = 1'b1;
            S_RECOVER: ;
            default:   busy = 1'b0;
        endcase
        prog_en  = en_any && (op_q == OP_PROG);
        erase_en = en_any && (op_q != OP_PROG);
        mass_sel = busy && (op_q == OP_MASS);
        done     = done_q;
        err      = err_q;
    end
endmodule

// File: rtl/flash_pe_sequencer_chk.sv
module flash_pe_sequencer_chk #(
    parameter int DIV_W   = 8,
    parameter int ADDR_W  = 5,
    parameter int DATA_W  = 16,
    parameter int TNVS_US = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DIV_W-1:0]  tick_div,
    input logic              busy,
    input logic              done,
    input logic              err,
    input logic [ADDR_W-1:0] fl_addr,
    input logic [DATA_W-1:0] fl_data,
    input logic              prog_en,
    input logic              erase_en,
    input logic              mass_sel,
    input logic              nvstr,
    input logic              hv_pulse
);
    int en_age;
    int div_eff;

    assign div_eff = (tick_div == '0) ? 1 : int'(tick_div);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     en_age <= 0;
        else if (!(prog_en || erase_en)) en_age <= 0;
        else                             en_age <= en_age + 1;
    end

    a_r3_enable_before_store: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nvstr) |-> (en_age >= TNVS_US * div_eff));

    a_r4_pulse_inside_store: assert property (@(posedge clk) disable iff (!rst_n)
        hv_pulse |-> (nvstr && (prog_en || erase_en)));

    a_r5_one_enable: assert property (@(posedge clk) disable iff (!rst_n)
        !(prog_en && erase_en));

    a_r5_mass_only_erase: assert property (@(posedge clk) disable iff (!rst_n)
        mass_sel |-> (busy && !prog_en));

    a_r6_enable_outlives_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hv_pulse) |-> ((prog_en || erase_en) && nvstr));

    a_r6_store_outlives_enable: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(prog_en || erase_en) |-> nvstr);

    a_r7_done_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    a_r9_err_marks_done: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (done && !nvstr && !hv_pulse));

    a_r13_bus_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(fl_addr) && $stable(fl_data)));
endmodule

bind flash_pe_sequencer flash_pe_sequencer_chk #(
    .DIV_W   (DIV_W),
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .TNVS_US (TNVS_US)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_div (tick_div),
    .busy     (busy),
    .done     (done),
    .err      (err),
    .fl_addr  (fl_addr),
    .fl_data  (fl_data),
    .prog_en  (prog_en),
    .erase_en (erase_en),
    .mass_sel (mass_sel),
    .nvstr    (nvstr),
    .hv_pulse (hv_pulse)
);

// File: tb/test_flash_pe_sequencer.sv
`timescale 1ns/1ps
module test_flash_pe_sequencer;
    localparam int ROWS = 4, WPR = 8, DATA_W = 16, DIV_W = 8;
    localparam int P_NVS = 5, P_PGS = 10, P_PROG = 20, P_ERASE = 30, P_ME = 60;
    localparam int P_NVH = 5, P_NVH1 = 12, P_RCV = 1, P_LIMIT = 50;
    localparam int AW = $clog2(ROWS * WPR);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [DIV_W-1:0]  tick_div = 8'd2;
    logic              start = 1'b0;
    logic [1:0]        op = 2'd0;
    logic [AW-1:0]     addr = '0;
    logic [DATA_W-1:0] wdata = '0;
    logic busy, done, err, prog_en, erase_en, mass_sel, nvstr, hv_pulse;
    logic [AW-1:0]     fl_addr;
    logic [DATA_W-1:0] fl_data;

    always #10 clk = ~clk;

    flash_pe_sequencer #(
        .ROWS(ROWS), .WORDS_PER_ROW(WPR), .DATA_W(DATA_W), .DIV_W(DIV_W),
        .TNVS_US(P_NVS), .TPGS_US(P_PGS), .TPROG_US(P_PROG), .TERASE_US(P_ERASE),
        .TME_US(P_ME), .TNVH_US(P_NVH), .TNVH1_US(P_NVH1), .TRCV_US(P_RCV),
        .HV_LIMIT_US(P_LIMIT)
    ) i_flash_pe_sequencer (
        .clk(clk), .rst_n(rst_n), .tick_div(tick_div), .start(start), .op(op),
        .addr(addr), .wdata(wdata), .busy(busy), .done(done), .err(err),
        .fl_addr(fl_addr), .fl_data(fl_data), .prog_en(prog_en), .erase_en(erase_en),
        .mass_sel(mass_sel), .nvstr(nvstr), .hv_pulse(hv_pulse)
    );

    typedef struct packed {
        logic busy, done, err, pe, ee, ms, nv, hv;
        logic [AW-1:0]     a;
        logic [DATA_W-1:0] d;
    } vec_t;

    vec_t  exp_q[$];
    string tag_q[$];
    int    total = 0, bad = 0, cyc = 0;
    bit    finished = 0;
    string note = "";
    string idle_tag = "R1";
    bit    written [ROWS*WPR];
    int    hv_row [ROWS];

    task automatic push(input int n, input vec_t v, input string t);
        for (int i = 0; i < n; i++) begin
            exp_q.push_back(v);
            tag_q.push_back({t, note});
        end
    endtask

    task automatic compare_now();
        vec_t  e, act;
        string t;
        if (exp_q.size() > 0) begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
        end else begin
            e = '0;
            t = idle_tag;
        end
        act = '{busy, done, err, prog_en, erase_en, mass_sel, nvstr, hv_pulse, fl_addr, fl_data};
        if (!e.busy) begin
            act.a = e.a;
            act.d = e.d;
        end
        total++;
        if (act !== e) begin
            bad++;
            $display("FAIL %s cycle %0d actual=%h expected=%h", t, cyc, act, e);
        end
        cyc++;
    endtask

    // Behavioural command model: decides acceptance and schedules per-cycle strobes.
    task automatic model_start(input logic [1:0] o, input logic [AW-1:0] a, input logic [DATA_W-1:0] d);
        vec_t v;
        int   dv, row;
        if (exp_q.size() > 0) begin
            idle_tag = "R8";
            return;
        end
        dv  = (tick_div == 0) ? 1 : int'(tick_div);
        row = int'(a) / WPR;
        v   = '0;
        if (o == 2'd3) begin
            v.done = 1; v.err = 1; push(1, v, "R12"); return;
        end
        if (o == 2'd0 && written[a]) begin
            v.done = 1; v.err = 1; push(1, v, "R9"); return;
        end
        if (o == 2'd0 && hv_row[row] + P_PROG > P_LIMIT) begin
            v.done = 1; v.err = 1; push(1, v, "R10"); return;
        end
        if (o == 2'd0) begin
            written[a] = 1; hv_row[row] += P_PROG;
        end else if (o == 2'd1) begin
            for (int w = 0; w < WPR; w++) written[row*WPR + w] = 0;
            hv_row[row] = 0;
        end else begin
            for (int w = 0; w < ROWS*WPR; w++) written[w] = 0;
            for (int r = 0; r < ROWS; r++) hv_row[r] = 0;
        end
        v.busy = 1; v.a = a; v.d = d; v.ms = (o == 2'd2);
        push(1, v, "R2");
        if (o == 2'd0) v.pe = 1; else v.ee = 1;
        push(P_NVS * dv, v, "R3");
        v.nv = 1;
        if (o == 2'd0) push(P_PGS * dv, v, "R4");
        v.hv = 1;
        push(((o == 2'd0) ? P_PROG : (o == 2'd1) ? P_ERASE : P_ME) * dv, v,
             (o == 2'd0) ? "R4" : "R5");
        v.hv = 0;
        push(1, v, "R6");
        v.pe = 0; v.ee = 0;
        push(((o == 2'd2) ? P_NVH1 : P_NVH) * dv, v, "R6");
        v.nv = 0;
        push(P_RCV * dv, v, "R7");
        v = '0; v.done = 1;
        push(1, v, "R7");
    endtask

    task automatic step(input bit st, input logic [1:0] o, input logic [AW-1:0] a, input logic [DATA_W-1:0] d);
        @(negedge clk);
        compare_now();
        start = st; op = o; addr = a; wdata = d;
        if (st) model_start(o, a, d);
    endtask

    task automatic idle_steps(input int n);
        for (int i = 0; i < n; i++) step(0, 2'd0, '0, '0);
    endtask

    task automatic run_cmd(input logic [1:0] o, input int a, input logic [DATA_W-1:0] d, input string nt);
        note = nt;
        step(1, o, AW'(a), d);
        while (exp_q.size() > 0) step(0, 2'd0, '0, '0);
        idle_steps(2);
        note = "";
    endtask

    initial begin
        for (int w = 0; w < ROWS*WPR; w++) written[w] = 0;
        for (int r = 0; r < ROWS; r++) hv_row[r] = 0;
        idle_steps(3);                       // R1 during reset
        rst_n = 1'b1;
        idle_steps(3);                       // R1 after reset
        run_cmd(2'd0, 3, 16'hA55A, "");      // R2..R7 word program
        run_cmd(2'd0, 3, 16'h1234, "");      // R9 repeat address
        run_cmd(2'd0, 4, 16'h0F0F, "");      // row 0 reaches 40 us
        run_cmd(2'd0, 5, 16'h7777, "");      // R10 budget exceeded
        // R8: a page erase of row 0 requested mid-command must be dropped
        note = " R8 busy";
        step(1, 2'd0, AW'(9), 16'hBEEF);
        idle_steps(20);
        step(1, 2'd1, AW'(0), 16'h0);
        while (exp_q.size() > 0) step(0, 2'd0, '0, '0);
        idle_steps(2);
        run_cmd(2'd0, 3, 16'h2222, " R8 row0 not erased");
        idle_tag = "R1";
        run_cmd(2'd3, 6, 16'h0, "");         // R12 undefined op
        run_cmd(2'd1, 2, 16'h0, "");         // R5 page erase of row 0
        run_cmd(2'd0, 3, 16'h3333, " R11 after page erase");
        run_cmd(2'd0, 9, 16'h4444, " R11 other row kept");
        run_cmd(2'd2, 0, 16'h0, "");         // R5 mass erase
        run_cmd(2'd0, 9, 16'h5555, " R11 after mass erase");
        run_cmd(2'd0, 5, 16'h6666, " R11 after mass erase");
        tick_div = 8'd1;
        idle_steps(2);
        run_cmd(2'd0, 20, 16'h9999, " R3 divider 1");
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule